// File: doc/BRIEF.md
# Masked Repeating Alarm Matcher

This block holds four alarm fields (seconds, minutes, hours, day of month) in BCD and compares them with a running BCD time that another block supplies. On every strobe of a one-per-second tick it decides whether the alarm matches. If it does, it emits a single-cycle interrupt pulse.

Bit 7 of each alarm field is a mask flag. There is no separate repeat-rate setting. The combination of mask flags across date, hour and minute chooses whether the alarm repeats monthly, daily, hourly, every minute or every second. A host loads each field through a simple write port with a field select. Writes to seconds, minutes or hours that fail a range check are dropped and leave the stored field unchanged.

Top module: `alarm_match`

## Requirements
- R1: After reset, irq_o is low and all four alarm fields read as zero. With no mask flag set, a tick while the time inputs are all 0x00 therefore gives a pulse.
- R2: A write stores wr_data_i whole (mask flag in bit 7) into the field that wr_sel_i picks: 0 seconds, 1 minutes, 2 hours, 3 date.
- R3: A seconds write is taken only when the value of its low 7 bits, read as tens*10+units (upper nibble times ten plus lower nibble), is at most 59. Otherwise the stored field is unchanged.
- R4: A minutes write follows the same low-7-bit rule and limit of 59 as R3.
- R5: An hours write is taken only when its low 6 bits, read as tens*10+units, give at most 23. A rejected write also leaves the hour mask flag unchanged.
- R6: A date write is always taken.
- R7: With no mask flag set, a tick fires only when all four fields match. Seconds and minutes compare bits 6:0, and hours and date compare bits 5:0.
- R8: With only the date mask set, a tick fires when hours, minutes and seconds match, whatever the date.
- R9: With the date and hour masks set and the minute and second masks clear, a tick fires when minutes and seconds match.
- R10: With the date, hour and minute masks set and the second mask clear, a tick fires when seconds match.
- R11: Every other mask pattern makes each tick fire, whatever the time inputs.
- R12: irq_o goes high only in the cycle after a sampled tick, and only for one cycle per single-cycle tick. Without a tick, irq_o stays low even when the time matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe once per second |
| time_sec_i | input | 8 | Current seconds, BCD |
| time_min_i | input | 8 | Current minutes, BCD |
| time_hour_i | input | 8 | Current hours, BCD |
| time_date_i | input | 8 | Current day of month, BCD |
| wr_en_i | input | 1 | Alarm field write strobe |
| wr_sel_i | input | 2 | Field select: 0 sec, 1 min, 2 hour, 3 date |
| wr_data_i | input | 8 | Write data, bit 7 is the mask flag |
| irq_o | output | 1 | Alarm interrupt pulse |

## Verification
The bench builds the block with its default field width of 8 bits and four fields. At that width the range checks can see codes whose low digit is not a decimal digit (0x5A, 0x4A), and these decode to values on both sides of the limit. The default width also gives the hour and date compare windows their two unused upper bits, so a time input that carries stray bits in those positions tests that the compare ignores them. With the default width every one of the sixteen mask patterns can be written, so the bench reaches every repeat mode as well as several of the patterns that fall through to the every-second mode.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

  localparam int unsigned FIELD_W = 8;
  localparam int unsigned N_FLD   = 4;
  localparam int unsigned SEL_W   = $clog2(N_FLD);
  localparam int unsigned MSK_BIT = FIELD_W - 1;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } fld_e;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MIN,
    RPT_SEC
  } rpt_e;

  typedef logic [FIELD_W-1:0] field_t;
  typedef field_t [N_FLD-1:0] field_arr_t;

  // Bits compared and range-checked per field.
  function automatic field_t field_mask(int unsigned idx);
    case (idx)
      FLD_SEC, FLD_MIN: field_mask = 8'h7F;
      default:          field_mask = 8'h3F;
    endcase
  endfunction

  function automatic int unsigned bcd_value(field_t v);
    bcd_value = int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic field_ok(int unsigned idx, field_t v);
    case (idx)
      FLD_SEC, FLD_MIN: field_ok = bcd_value(v & field_mask(idx)) <= 59;
      FLD_HOUR:         field_ok = bcd_value(v & field_mask(idx)) <= 23;
      default:          field_ok = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_match_pkg::*;
#(
  parameter int unsigned NF = N_FLD,
  parameter int unsigned W  = FIELD_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [SW-1:0]         wr_sel_i,
  input  logic [W-1:0]          wr_data_i,
  output logic [NF-1:0][W-1:0]  alm_o
);

  for (genvar g = 0; g < NF; g++) begin : g_fld
    logic take;
    assign take = wr_en_i && (wr_sel_i == SW'(g)) && field_ok(g, wr_data_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   alm_o[g] <= '0;
      else if (take) alm_o[g] <= wr_data_i;
    end
  end

endmodule

// File: rtl/alarm_mode_dec.sv
module alarm_mode_dec
  import alarm_match_pkg::*;
#(
  parameter int unsigned NF = N_FLD
) (
  input  logic [NF-1:0] msk_i,
  output rpt_e          rpt_o,
  output logic [NF-1:0] cmp_en_o
);

  // Nesting: date, then hour, then minute masks widen the period downward.
  always_comb begin
    case ({msk_i[FLD_DATE], msk_i[FLD_HOUR], msk_i[FLD_MIN], msk_i[FLD_SEC]})
      4'b0000: rpt_o = RPT_MONTH;
      4'b1000: rpt_o = RPT_DAY;
      4'b1100: rpt_o = RPT_HOUR;
      4'b1110: rpt_o = RPT_MIN;
      default: rpt_o = RPT_SEC;
    endcase
  end

  always_comb begin
    cmp_en_o = '0;
    case (rpt_o)
      RPT_MONTH: cmp_en_o = 4'b1111;
      RPT_DAY:   cmp_en_o = 4'b0111;
      RPT_HOUR:  cmp_en_o = 4'b0011;
      RPT_MIN:   cmp_en_o = 4'b0001;
      default:   cmp_en_o = 4'b0000;
    endcase
  end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_match_pkg::*;
#(
  parameter int unsigned NF = N_FLD,
  parameter int unsigned W  = FIELD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [NF-1:0][W-1:0] now_i,
  input  logic [NF-1:0][W-1:0] alm_i,
  input  logic [NF-1:0]        cmp_en_i,
  output logic                 irq_o
);

  logic [NF-1:0] eq;
  logic          hit;

  for (genvar g = 0; g < NF; g++) begin : g_eq
    assign eq[g] = ((now_i[g] ^ alm_i[g]) & field_mask(g)) == '0;
  end

  assign hit = &(eq | ~cmp_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= tick_i & hit;
  end

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_match_pkg::*;
#(
  parameter int unsigned NF = N_FLD,
  parameter int unsigned W  = FIELD_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [W-1:0]  time_sec_i,
  input  logic [W-1:0]  time_min_i,
  input  logic [W-1:0]  time_hour_i,
  input  logic [W-1:0]  time_date_i,
  input  logic          wr_en_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          irq_o
);

  logic [NF-1:0][W-1:0] alm_q;
  logic [NF-1:0][W-1:0] now;
  logic [NF-1:0]        msk;
  logic [NF-1:0]        cmp_en;
  rpt_e                 rpt;

  assign now[FLD_SEC]  = time_sec_i;
  assign now[FLD_MIN]  = time_min_i;
  assign now[FLD_HOUR] = time_hour_i;
  assign now[FLD_DATE] = time_date_i;

  for (genvar g = 0; g < NF; g++) begin : g_msk
    assign msk[g] = alm_q[g][W-1];
  end

  alarm_regs #(.NF(NF), .W(W), .SW(SW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .alm_o     (alm_q)
  );

  alarm_mode_dec #(.NF(NF)) u_dec (
    .msk_i    (msk),
    .rpt_o    (rpt),
    .cmp_en_o (cmp_en)
  );

  alarm_cmp #(.NF(NF), .W(W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .now_i    (now),
    .alm_i    (alm_q),
    .cmp_en_i (cmp_en),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/alarm_match_chk.sv
module alarm_match_chk
  import alarm_match_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [7:0]       time_sec_i,
  input logic [7:0]       time_min_i,
  input logic [7:0]       time_hour_i,
  input logic [7:0]       time_date_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [7:0]       wr_data_i,
  input logic             irq_o,
  input logic [3:0][7:0]  alm_i
);

  logic [3:0] m;
  logic       odd_pat;
  logic [3:0] dig_hi;
  logic [3:0] dig_lo;
  logic       sec_bad;
  logic       hour_bad;

  assign m        = {alm_i[3][7], alm_i[2][7], alm_i[1][7], alm_i[0][7]};
  assign odd_pat  = (m != 4'b0000) && (m != 4'b1000) && (m != 4'b1100) && (m != 4'b1110);
  assign dig_hi   = wr_data_i[7:4];
  assign dig_lo   = wr_data_i[3:0];
  assign sec_bad  = ({1'b0, dig_hi[2:0]} * 10 + dig_lo) > 59;
  assign hour_bad = ({2'b0, dig_hi[1:0]} * 10 + dig_lo) > 23;

  a_r12_irq_follows_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i));

  a_r7_month_needs_date: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(m == 4'b0000) |-> $past(time_date_i[5:0] == alm_i[3][5:0]));

  a_r8_day_needs_hour: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(m == 4'b1000) |-> $past(time_hour_i[5:0] == alm_i[2][5:0]));

  a_r9_hour_needs_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(m == 4'b1100) |-> $past(time_min_i[6:0] == alm_i[1][6:0]));

  a_r10_min_needs_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && $past(m == 4'b1110) |-> $past(time_sec_i[6:0] == alm_i[0][6:0]));

  a_r11_odd_pattern_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i) && $past(odd_pat) |-> irq_o);

  a_r3_sec_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_sel_i == 2'd0) && sec_bad |=> $stable(alm_i[0]));

  a_r5_hour_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_sel_i == 2'd2) && hour_bad |=> $stable(alm_i[2]));

endmodule

bind alarm_match alarm_match_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .time_sec_i  (time_sec_i),
  .time_min_i  (time_min_i),
  .time_hour_i (time_hour_i),
  .time_date_i (time_date_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .irq_o       (irq_o),
  .alm_i       (alm_q)
);

// File: tb/sim_alarm_match.sv
module sim_alarm_match;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] t_sec = '0, t_min = '0, t_hour = '0, t_date = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       irq;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  alarm_match u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .time_sec_i  (t_sec),
    .time_min_i  (t_min),
    .time_hour_i (t_hour),
    .time_date_i (t_date),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .irq_o       (irq)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: irq_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_t(input logic [7:0] s, m, h, d);
    @(negedge clk);
    t_sec = s; t_min = m; t_hour = h; t_date = d;
  endtask

  task automatic tick_exp(input bit e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: scoreboard pop on each tick, then pulse-width check.
  initial begin
    forever begin
      @(posedge clk);
      if (tick) begin
        bit    e;
        string tg;
        @(negedge clk);
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R12: unexpected tick, queue empty");
        end else begin
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(irq, e, tg);
        end
        @(negedge clk);
        check(irq, 1'b0, "R12 pulse one cycle");
      end
    end
  end

  initial begin
    int unsigned cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R1 reset irq low");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(irq, 1'b0, "R1 irq low after reset");

    // R1: zeroed fields, monthly
    set_t(8'h00, 8'h00, 8'h00, 8'h00); tick_exp(1'b1, "R1 zero fields match");
    set_t(8'h01, 8'h00, 8'h00, 8'h00); tick_exp(1'b0, "R7 sec mismatch");

    // R2 / R7 monthly
    wr(2'd0, 8'h30); wr(2'd1, 8'h45); wr(2'd2, 8'h12); wr(2'd3, 8'h15);
    set_t(8'h30, 8'h45, 8'h12, 8'h15); tick_exp(1'b1, "R2 R7 full match");
    set_t(8'h30, 8'h45, 8'h12, 8'h16); tick_exp(1'b0, "R7 date mismatch");
    set_t(8'h30, 8'h45, 8'h13, 8'h15); tick_exp(1'b0, "R7 hour mismatch");
    set_t(8'hB0, 8'hC5, 8'hD2, 8'hD5); tick_exp(1'b1, "R7 upper bits ignored");

    // R8 daily
    wr(2'd3, 8'h95);
    set_t(8'h30, 8'h45, 8'h12, 8'h20); tick_exp(1'b1, "R8 date ignored");
    set_t(8'h30, 8'h46, 8'h12, 8'h20); tick_exp(1'b0, "R8 min mismatch");

    // R9 hourly
    wr(2'd2, 8'h92);
    set_t(8'h30, 8'h45, 8'h05, 8'h20); tick_exp(1'b1, "R9 hour ignored");
    set_t(8'h31, 8'h45, 8'h05, 8'h20); tick_exp(1'b0, "R9 sec mismatch");

    // R10 minutely
    wr(2'd1, 8'hC5);
    set_t(8'h30, 8'h10, 8'h05, 8'h20); tick_exp(1'b1, "R10 min ignored");
    set_t(8'h31, 8'h10, 8'h05, 8'h20); tick_exp(1'b0, "R10 sec mismatch");

    // R11 other patterns
    wr(2'd0, 8'hB0);
    tick_exp(1'b1, "R11 all masks");
    wr(2'd0, 8'h30); wr(2'd2, 8'h12);
    set_t(8'h00, 8'h00, 8'h00, 8'h01); tick_exp(1'b1, "R11 date+min masks");
    wr(2'd2, 8'h92);
    tick_exp(1'b0, "R10 back to minutely");

    // R3 seconds range
    wr(2'd0, 8'h60); wr(2'd0, 8'h5A);
    set_t(8'h30, 8'h00, 8'h00, 8'h01); tick_exp(1'b1, "R3 bad sec writes dropped");
    wr(2'd0, 8'h4A);
    set_t(8'h4A, 8'h00, 8'h00, 8'h01); tick_exp(1'b1, "R3 sec 0x4A taken");
    set_t(8'h30, 8'h00, 8'h00, 8'h01); tick_exp(1'b0, "R3 old sec replaced");

    // R4 minutes range (hourly)
    wr(2'd1, 8'h45); wr(2'd1, 8'h60);
    set_t(8'h4A, 8'h45, 8'h00, 8'h01); tick_exp(1'b1, "R4 bad min dropped");
    wr(2'd1, 8'h59);
    set_t(8'h4A, 8'h59, 8'h00, 8'h01); tick_exp(1'b1, "R4 min 59 taken");
    set_t(8'h4A, 8'h45, 8'h00, 8'h01); tick_exp(1'b0, "R4 old min replaced");

    // R5 hours range (daily)
    wr(2'd2, 8'h12); wr(2'd2, 8'h24);
    set_t(8'h4A, 8'h59, 8'h12, 8'h01); tick_exp(1'b1, "R5 hour 24 dropped");
    wr(2'd2, 8'hA4);
    set_t(8'h4A, 8'h59, 8'h05, 8'h01); tick_exp(1'b0, "R5 masked bad hour dropped");
    wr(2'd2, 8'h23);
    set_t(8'h4A, 8'h59, 8'h23, 8'h01); tick_exp(1'b1, "R5 hour 23 taken");

    // R6 date always taken (monthly)
    wr(2'd3, 8'h3F);
    set_t(8'h4A, 8'h59, 8'h23, 8'h3F); tick_exp(1'b1, "R6 date 0x3F taken");
    set_t(8'h4A, 8'h59, 8'h23, 8'h15); tick_exp(1'b0, "R6 date mismatch");
    wr(2'd3, 8'h00);
    set_t(8'h4A, 8'h59, 8'h23, 8'h00); tick_exp(1'b1, "R6 date 0x00 taken");

    // R12 no tick, matching time
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(irq, 1'b0, "R12 no tick no irq");
    end

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R12: %0d results missing, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule